// File: doc/BRIEF.md
# Sector Bit-Flip Corrector for an 8-Error BCH Result

This block sits behind a BCH decoder that protects 512-byte sectors. It receives the decoder's result for one sector as three 32-bit location words and one status word. The status word carries a 4-bit error count and the top byte of a packed 104-bit location vector. The block extracts eight 13-bit bit positions from that vector and repairs their encoding. Each position in range is applied to a byte-wide sector buffer as one read-modify-write flip. An erased-page verdict, produced elsewhere, arrives with its own correction count and is used only as an input.

A run begins with a single-cycle `start_i` while the block is idle. On that cycle the block latches the location words, the count and the erased-page inputs. When the run ends it pulses `done_o` and presents the number of flips it applied, or raises an uncorrectable flag. The buffer port assumes a synchronous RAM with one cycle of read latency, of the kind block RAM gives.

Top module: `bch8_sector_fixer`

## Requirements
- R1: The error count is read from status bits [13:10]. A count of 0 ends the run with `fix_cnt_o` = 0 and `uncorr_o` = 0, and the buffer is not written.
- R2: A count above 8 with `erased_i` low ends the run with `uncorr_o` = 1 and `fix_cnt_o` = 0, and the buffer is not written.
- R3: A count above 8 with `erased_i` high ends the run with `fix_cnt_o` = `erased_cnt_i` and `uncorr_o` = 0, and the buffer is not written. When the count is 8 or less, `erased_i` has no effect.
- R4: The 104-bit location vector is {status[23:16], w3, w2, w1}, with w1 in the least significant bits. Location k (k = 0..7) is bits [13k+12:13k], so locations 2, 4 and 7 span two words.
- R5: Each stored 13-bit location is a bit position with bits 0 and 1 inverted. The block inverts those two bits again before it uses the value.
- R6: A repaired position greater than 4096 is skipped and not counted. Position 4096 itself is applied; it lands on byte 512, bit 0.
- R7: Position p flips bit p mod 8 of byte p div 8. The block reads the byte, and two cycles later writes back the same address with only that bit inverted. A read and a write never occur in the same cycle.
- R8: Locations are used in order from 0 upward, one per reported error. Locations at or beyond the count are ignored, and `fix_cnt_o` equals the number of flips applied.
- R9: `done_o` is a one-cycle pulse, and `busy_o` is low while it is high. `busy_o` rises the cycle after an accepted start. A start while busy is ignored.
- R10: After reset `busy_o`, `done_o`, `ram_rd_en_o` and `ram_wr_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run; accepted only when idle |
| loc_w1_i | input | 32 | Location word, least significant part |
| loc_w2_i | input | 32 | Location word, middle part |
| loc_w3_i | input | 32 | Location word, upper part |
| stat_w_i | input | 32 | Status word: count in [13:10], top location byte in [23:16] |
| erased_i | input | 1 | Erased-page verdict from the outside check |
| erased_cnt_i | input | 4 | Count reported when the erased verdict overrides |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fix_cnt_o | output | 4 | Flips applied (or the erased count) |
| uncorr_o | output | 1 | Sector cannot be corrected |
| ram_addr_o | output | 10 | Sector buffer byte address |
| ram_rd_en_o | output | 1 | Buffer read strobe |
| ram_rdata_i | input | 8 | Buffer read data, one cycle after the strobe |
| ram_wr_en_o | output | 1 | Buffer write strobe |
| ram_wdata_o | output | 8 | Buffer write data |

## Verification
The assertions assume that the sector buffer returns read data exactly one cycle after the read strobe. They also assume that nothing else writes the buffer during a run, since the write-back is computed from the byte that was just read. The stimulus pulses start for a single cycle and holds the location and status inputs on that cycle only, which relies on the block latching them. The bench's buffer model is an ideal one-cycle RAM that only the block touches. Unused status bits carry nonzero filler to show that only the count field and the top location byte are decoded.

// File: rtl/bch8_fix_pkg.sv
package bch8_fix_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_PICK,
    ST_RD,
    ST_WR
  } fix_state_e;

endpackage

// File: rtl/bch8_loc_unpack.sv
module bch8_loc_unpack #(
  parameter int IDX_W     = 13,
  parameter int NIDX      = 8,
  parameter int LIMIT     = 4096,
  parameter int FLIP_LSBS = 2
) (
  input  logic [NIDX*IDX_W-1:0]       vec_i,
  output logic [NIDX-1:0][IDX_W-1:0]  idx_o,
  output logic [NIDX-1:0]             ok_o
);

  localparam logic [IDX_W-1:0] FIX_MASK = IDX_W'((1 << FLIP_LSBS) - 1);
  localparam logic [IDX_W:0]   LIMIT_V  = (IDX_W + 1)'(LIMIT);

  // Each location is a fixed slice; undo the low-bit inversion and range check.
  for (genvar k = 0; k < NIDX; k++) begin : g_loc
    assign idx_o[k] = vec_i[k*IDX_W +: IDX_W] ^ FIX_MASK;
    assign ok_o[k]  = ({1'b0, idx_o[k]} <= LIMIT_V);
  end

endmodule

// File: rtl/bch8_flip_seq.sv
module bch8_flip_seq
  import bch8_fix_pkg::*;
#(
  parameter int IDX_W   = 13,
  parameter int NIDX    = 8,
  parameter int CNT_W   = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 10,
  parameter int MAX_ERR = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [NIDX*IDX_W-1:0]      vec_i,
  input  logic                       erased_i,
  input  logic [CNT_W-1:0]           erased_cnt_i,
  output logic [NIDX*IDX_W-1:0]      vec_q_o,
  input  logic [NIDX-1:0][IDX_W-1:0] idx_i,
  input  logic [NIDX-1:0]            ok_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [CNT_W-1:0]           fix_cnt_o,
  output logic                       uncorr_o,
  output logic [ADDR_W-1:0]          ram_addr_o,
  output logic                       ram_rd_en_o,
  input  logic [DATA_W-1:0]          ram_rdata_i,
  output logic                       ram_wr_en_o,
  output logic [DATA_W-1:0]          ram_wdata_o
);

  localparam int K_W   = (NIDX > 1) ? $clog2(NIDX) : 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_ERR);

  fix_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                erased_q;
  logic [CNT_W-1:0]    ecnt_q;
  logic [K_W-1:0]      k_q;
  logic [CNT_W-1:0]    left_q;
  logic [CNT_W-1:0]    applied_q;
  logic [BIT_W-1:0]    bit_q;

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vec_q_o     <= '0;
      cnt_q       <= '0;
      erased_q    <= 1'b0;
      ecnt_q      <= '0;
      k_q         <= '0;
      left_q      <= '0;
      applied_q   <= '0;
      bit_q       <= '0;
      done_o      <= 1'b0;
      fix_cnt_o   <= '0;
      uncorr_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_rd_en_o <= 1'b0;
      ram_wr_en_o <= 1'b0;
      ram_wdata_o <= '0;
    end else begin
      done_o      <= 1'b0;
      ram_rd_en_o <= 1'b0;
      ram_wr_en_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vec_q_o  <= vec_i;
            cnt_q    <= cnt_i;
            erased_q <= erased_i;
            ecnt_q   <= erased_cnt_i;
            state_q  <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (cnt_q == '0) begin
            done_o    <= 1'b1;
            fix_cnt_o <= '0;
            uncorr_o  <= 1'b0;
            state_q   <= ST_IDLE;
          end else if (cnt_q > MAX_V) begin
            done_o    <= 1'b1;
            fix_cnt_o <= erased_q ? ecnt_q : '0;
            uncorr_o  <= ~erased_q;
            state_q   <= ST_IDLE;
          end else begin
            k_q       <= '0;
            left_q    <= cnt_q;
            applied_q <= '0;
            state_q   <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (left_q == '0) begin
            done_o    <= 1'b1;
            fix_cnt_o <= applied_q;
            uncorr_o  <= 1'b0;
            state_q   <= ST_IDLE;
          end else begin
            if (ok_i[k_q]) begin
              ram_addr_o  <= ADDR_W'(idx_i[k_q] >> BIT_W);
              bit_q       <= idx_i[k_q][BIT_W-1:0];
              ram_rd_en_o <= 1'b1;
              state_q     <= ST_RD;
            end
            k_q    <= k_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        end
        ST_RD: begin
          state_q <= ST_WR;
        end
        ST_WR: begin
          ram_wdata_o <= ram_rdata_i ^ (DATA_W'(1) << bit_q);
          ram_wr_en_o <= 1'b1;
          applied_q   <= applied_q + 1'b1;
          state_q     <= ST_PICK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11-style port discipline folded into R7: never read and write together.
  p_rw_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd_en_o && ram_wr_en_o));

  p_write_follows_read_r7: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en_o |-> ($past(ram_rd_en_o, 2) && ram_addr_o == $past(ram_addr_o, 2)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  p_uncorr_no_fix_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && uncorr_o) |-> fix_cnt_o == '0);

  p_applied_bound_r8: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en_o |-> (applied_q != '0 && applied_q <= cnt_q));

endmodule

// File: rtl/bch8_sector_fixer.sv
module bch8_sector_fixer #(
  parameter int WORD_W       = 32,
  parameter int IDX_W        = 13,
  parameter int NIDX         = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 4,
  parameter int CNT_LSB      = 10,
  parameter int TAIL_LSB     = 16,
  parameter int MAX_ERR      = 8,
  parameter int FLIP_LSBS    = 2,
  localparam int LIMIT       = SECTOR_BYTES * DATA_W,
  localparam int ADDR_W      = $clog2(LIMIT + 1) - $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] loc_w1_i,
  input  logic [WORD_W-1:0] loc_w2_i,
  input  logic [WORD_W-1:0] loc_w3_i,
  input  logic [WORD_W-1:0] stat_w_i,
  input  logic              erased_i,
  input  logic [CNT_W-1:0]  erased_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fix_cnt_o,
  output logic              uncorr_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_rd_en_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_wr_en_o,
  output logic [DATA_W-1:0] ram_wdata_o
);

  localparam int VEC_W  = NIDX * IDX_W;
  localparam int TAIL_W = VEC_W - 3 * WORD_W;

  logic [VEC_W-1:0]             vec_in;
  logic [VEC_W-1:0]             vec_q;
  logic [NIDX-1:0][IDX_W-1:0]   idx;
  logic [NIDX-1:0]              idx_ok;
  logic                         unused_stat;

  assign vec_in = {stat_w_i[TAIL_LSB +: TAIL_W], loc_w3_i, loc_w2_i, loc_w1_i};
  assign unused_stat = ^{stat_w_i[CNT_LSB-1:0],
                         stat_w_i[TAIL_LSB-1:CNT_LSB+CNT_W],
                         stat_w_i[WORD_W-1:TAIL_LSB+TAIL_W]};

  bch8_loc_unpack #(
    .IDX_W    (IDX_W),
    .NIDX     (NIDX),
    .LIMIT    (LIMIT),
    .FLIP_LSBS(FLIP_LSBS)
  ) u_unpack (
    .vec_i(vec_q),
    .idx_o(idx),
    .ok_o (idx_ok)
  );

  bch8_flip_seq #(
    .IDX_W  (IDX_W),
    .NIDX   (NIDX),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .MAX_ERR(MAX_ERR)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cnt_i       (stat_w_i[CNT_LSB +: CNT_W]),
    .vec_i       (vec_in),
    .erased_i    (erased_i),
    .erased_cnt_i(erased_cnt_i),
    .vec_q_o     (vec_q),
    .idx_i       (idx),
    .ok_i        (idx_ok),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fix_cnt_o   (fix_cnt_o),
    .uncorr_o    (uncorr_o),
    .ram_addr_o  (ram_addr_o),
    .ram_rd_en_o (ram_rd_en_o),
    .ram_rdata_i (ram_rdata_i),
    .ram_wr_en_o (ram_wr_en_o),
    .ram_wdata_o (ram_wdata_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !ram_rd_en_o && !ram_wr_en_o));

endmodule

// File: tb/bch8_sector_fixer_bench.sv
module bch8_sector_fixer_bench;

  localparam int NB = 513;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] w1 = '0, w2 = '0, w3 = '0, stat = '0;
  logic        erased = 1'b0;
  logic [3:0]  ecnt = '0;
  logic        busy, done, uncorr, rd_en, wr_en;
  logic [3:0]  fix_cnt;
  logic [9:0]  addr;
  logic [7:0]  rdata = '0, wdata;

  logic [7:0] mem  [NB];
  logic [7:0] gold [NB];

  int checks = 0;
  int fails = 0;
  int wr_seen = 0;
  int done_seen = 0;

  always #10 clk = ~clk;

  bch8_sector_fixer u_bch8_sector_fixer (
    .clk(clk), .rst(rst), .start_i(start),
    .loc_w1_i(w1), .loc_w2_i(w2), .loc_w3_i(w3), .stat_w_i(stat),
    .erased_i(erased), .erased_cnt_i(ecnt),
    .busy_o(busy), .done_o(done), .fix_cnt_o(fix_cnt), .uncorr_o(uncorr),
    .ram_addr_o(addr), .ram_rd_en_o(rd_en), .ram_rdata_i(rdata),
    .ram_wr_en_o(wr_en), .ram_wdata_o(wdata)
  );

  always @(posedge clk) begin
    if (wr_en) begin mem[addr] <= wdata; wr_seen <= wr_seen + 1; end
    if (rd_en) rdata <= mem[addr];
    if (done) done_seen <= done_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < NB; i++) begin
      mem[i]  = 8'(i * 37 + 5);
      gold[i] = 8'(i * 37 + 5);
    end
  endtask

  function automatic int gold_apply(input int cnt, input int pos[8]);
    int n = 0;
    if (cnt == 0 || cnt > 8) return 0;
    for (int k = 0; k < cnt; k++) begin
      if (pos[k] <= 4096) begin
        gold[pos[k] >> 3] ^= 8'(1 << (pos[k] & 7));
        n++;
      end
    end
    return n;
  endfunction

  task automatic mem_cmp(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NB; i++)
      if (mem[i] !== gold[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, req, "buffer bytes differing (first shown as actual idx)",
        first, -1);
  endtask

  task automatic launch(input int cnt, input int pos[8], input bit er,
                        input int ec);
    logic [103:0] v = '0;
    for (int k = 0; k < 8; k++) v[k*13 +: 13] = 13'(pos[k]) ^ 13'h3;
    w1 = v[31:0]; w2 = v[63:32]; w3 = v[95:64];
    stat = 32'hC300_02A5;
    stat[23:16] = v[103:96];
    stat[13:10] = 4'(cnt);
    erased = er; ecnt = 4'(ec);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w1 = '1; w2 = '1; w3 = '1; stat = '1;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk(seen, req, "done observed", int'(seen), 1);
  endtask

  task automatic run(input int cnt, input int pos[8], input bit er, input int ec,
                     input int exp_fix, input bit exp_unc, input string req);
    int w0 = wr_seen;
    int nflip;
    preload();
    nflip = gold_apply(cnt, pos);
    launch(cnt, pos, er, ec);
    wait_done(req);
    chk(fix_cnt == 4'(exp_fix), req, "fix count", fix_cnt, exp_fix);
    chk(uncorr == exp_unc, req, "uncorrectable flag", uncorr, exp_unc);
    @(negedge clk);
    chk(wr_seen - w0 == nflip, req, "buffer writes", wr_seen - w0, nflip);
    mem_cmp(req);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R10", "busy|done after reset", busy | done, 0);
    chk(!rd_en && !wr_en, "R10", "ram strobes after reset", rd_en | wr_en, 0);
  endtask

  task automatic t_zero_count();
    run(0, '{100, 200, 300, 400, 500, 600, 700, 800}, 1'b0, 0, 0, 1'b0, "R1");
  endtask

  task automatic t_full_eight();
    // R4 straddling slots 2,4,7 and R5 low-bit inversion, R7 bit mapping
    run(8, '{5, 1000, 1234, 77, 4000, 3333, 2222, 4095}, 1'b0, 0, 8, 1'b0,
        "R4/R5/R7");
  endtask

  task automatic t_partial();
    run(3, '{17, 18, 19, 2000, 2001, 2002, 2003, 2004}, 1'b0, 0, 3, 1'b0, "R8");
  endtask

  task automatic t_range();
    run(5, '{4096, 4097, 8191, 12, 4100, 0, 0, 0}, 1'b0, 0, 2, 1'b0, "R6");
    chk(mem[512] == 8'(512 * 37 + 5) ^ 8'h01, "R6", "byte 512 after 4096 flip",
        mem[512], 8'(512 * 37 + 5) ^ 8'h01);
  endtask

  task automatic t_same_byte();
    run(4, '{9, 9, 10, 15, 0, 0, 0, 0}, 1'b0, 0, 4, 1'b0, "R7");
  endtask

  task automatic t_uncorrectable();
    run(9, '{1, 2, 3, 4, 5, 6, 7, 8}, 1'b0, 3, 0, 1'b1, "R2");
  endtask

  task automatic t_erased();
    run(15, '{1, 2, 3, 4, 5, 6, 7, 8}, 1'b1, 5, 5, 1'b0, "R3");
    run(2, '{40, 41, 3, 4, 5, 6, 7, 8}, 1'b1, 7, 2, 1'b0, "R3");
  endtask

  task automatic t_busy_block();
    int d0;
    int p1[8] = '{50, 60, 70, 80, 90, 100, 110, 120};
    int p2[8] = '{3000, 3001, 3002, 3003, 3004, 3005, 3006, 3007};
    int nflip;
    preload();
    nflip = gold_apply(6, p1);
    d0 = done_seen;
    launch(6, p1, 1'b0, 0);
    chk(busy, "R9", "busy after start", busy, 1);
    @(negedge clk);
    launch(8, p2, 1'b0, 0);
    wait_done("R9");
    chk(!busy, "R9", "busy with done", busy, 0);
    chk(fix_cnt == 4'(nflip), "R9", "fix count of first run", fix_cnt, nflip);
    repeat (40) @(negedge clk);
    chk(done_seen - d0 == 1, "R9", "done pulses", done_seen - d0, 1);
    mem_cmp("R9");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    preload();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_full_eight();
    t_partial();
    t_range();
    t_same_byte();
    t_uncorrectable();
    t_erased();
    t_busy_block();
    summary();
    $finish;
  end

endmodule